// File: doc/BRIEF.md
# Universal Bidirectional Bus Register

This block carries a data word between two ports, A and B, with one independent path for each direction. Each path runs in one of three modes. It can pass its input straight through, hold a stored word, or capture its input on a rising edge of its own data clock. A latch enable selects pass-through. An active-low clock enable gates capture. An active-low output enable decides whether the path drives its destination port.

Both ports face off-chip tri-state pads. Each port's receive side therefore arrives as a data vector plus a per-bit "driven" flag, and its transmit side leaves as a data vector plus one drive enable for the pad ring. A weak keeper on each receive side remembers the last level seen on every bit that was driven. It supplies that level while the bit floats. All logic runs in one system clock domain. The per-direction data clocks are treated as sampled signals, and their rising transitions are detected against the system clock.

Top module: `ubr_xcvr`

## Requirements
- R1: With ab_le high and ab_oe_n low, b_tx_data equals the effective A input in the same cycle, with no clock edge needed.
- R2: With ab_le low and no qualified rising transition of ab_clk, b_tx_data keeps its value, whether ab_clk stays high or stays low.
- R3: With ab_le low and ab_clken_n low, a system-clock edge that first samples ab_clk high (after sampling it low) stores the effective A input; the stored word appears on b_tx_data after that edge.
- R4: While ab_clken_n is high, rising transitions of ab_clk are ignored and the stored word stays unchanged whatever the A input does.
- R5: While ab_oe_n is high, b_tx_en is 0 and b_tx_data is all zeros; while it is low, b_tx_en is 1. Both output enables low at once is a usage error that the checker flags.
- R6: When ab_le falls, the stored word equals the effective A input sampled at the last system-clock edge on which ab_le was high.
- R7: The B-to-A path, with ba_le, ba_clk, ba_clken_n and ba_oe_n, drives a_tx_data and a_tx_en with the same behaviour as R1 to R6. It is independent of the A-to-B controls.
- R8: For every receive bit, a driven flag of 1 makes the effective input equal the received data bit, and the keeper samples that bit at each system-clock edge. A driven flag of 0 makes the effective input equal the last sampled value.
- R9: rst high at a system-clock edge clears both stored words and both keepers to zero. It also makes a data clock that is already high at the end of reset not count as a rising transition. Output enables are unaffected by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_rx_data | input | 18 | Level received on port A pads |
| a_rx_drv | input | 18 | Per-bit flag: port A bit is actively driven |
| b_rx_data | input | 18 | Level received on port B pads |
| b_rx_drv | input | 18 | Per-bit flag: port B bit is actively driven |
| ab_le | input | 1 | A-to-B pass-through select |
| ab_clk | input | 1 | A-to-B data clock (sampled) |
| ab_clken_n | input | 1 | A-to-B capture enable, active low |
| ab_oe_n | input | 1 | A-to-B drive enable, active low |
| ba_le | input | 1 | B-to-A pass-through select |
| ba_clk | input | 1 | B-to-A data clock (sampled) |
| ba_clken_n | input | 1 | B-to-A capture enable, active low |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| b_tx_data | output | 18 | Word driven toward port B pads |
| b_tx_en | output | 1 | Port B pad drive enable |
| a_tx_data | output | 18 | Word driven toward port A pads |
| a_tx_en | output | 1 | Port A pad drive enable |

## Verification
The checker watches several rules on every cycle. It checks that pass-through matches a fully driven input and that a disabled port drives nothing. It checks that the stored word moves only on a qualified data-clock edge, and that the edge loads the sampled input. It also checks that the keeper restores a bit that has just floated, and that the two drive enables never overlap. Some behaviour is visible only in the bench's scenarios. These include the word caught when pass-through closes, merged partial-float patterns, the independence of the two directions, and reset with a data clock already held high.

// File: rtl/ubr_pkg.sv
package ubr_pkg;

    localparam int unsigned UBR_WORD_W = 18;

    // Per-direction control bundle
    typedef struct packed {
        logic le;
        logic dclk;
        logic clken_n;
        logic oe_n;
    } lane_ctrl_t;

    // Storage update decision for one direction
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_TRACK = 2'd1,
        ST_LOAD  = 2'd2
    } store_op_t;

    function automatic store_op_t pick_op(input logic le, input logic rise,
                                          input logic clken_n);
        if (le)
            return ST_TRACK;
        else if (rise && !clken_n)
            return ST_LOAD;
        else
            return ST_HOLD;
    endfunction

endpackage

// File: rtl/ubr_keeper.sv
module ubr_keeper #(
    parameter int unsigned W = ubr_pkg::UBR_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad_val,
    input  logic [W-1:0] pad_drv,
    output logic [W-1:0] eff
);
    logic [W-1:0] held_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                held_q[i] <= 1'b0;
            else if (pad_drv[i])
                held_q[i] <= pad_val[i];
        end
        assign eff[i] = pad_drv[i] ? pad_val[i] : held_q[i];
    end
endmodule

// File: rtl/ubr_edge_det.sv
module ubr_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise
);
    logic prev_q;

    // Reset to 1 so a level already high after reset is not an edge
    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b1;
        else
            prev_q <= sig;
    end

    assign rise = sig & ~prev_q;
endmodule

// File: rtl/ubr_lane.sv
module ubr_lane
    import ubr_pkg::*;
#(
    parameter int unsigned W = UBR_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  lane_ctrl_t   ctrl,
    input  logic [W-1:0] din,
    output logic [W-1:0] tx_data,
    output logic         tx_en
);
    logic         rise;
    store_op_t    op;
    logic [W-1:0] word_q;
    logic [W-1:0] sel;

    ubr_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  (ctrl.dclk),
        .rise (rise)
    );

    always_comb op = pick_op(ctrl.le, rise, ctrl.clken_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            unique case (op)
                ST_TRACK, ST_LOAD: word_q <= din;
                default:           word_q <= word_q;
            endcase
        end
    end

    always_comb begin
        sel     = ctrl.le ? din : word_q;
        tx_en   = ~ctrl.oe_n;
        tx_data = tx_en ? sel : '0;
    end
endmodule

// File: rtl/ubr_xcvr.sv
module ubr_xcvr
    import ubr_pkg::*;
#(
    parameter int unsigned W = UBR_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_rx_data,
    input  logic [W-1:0] a_rx_drv,
    input  logic [W-1:0] b_rx_data,
    input  logic [W-1:0] b_rx_drv,
    input  logic         ab_le,
    input  logic         ab_clk,
    input  logic         ab_clken_n,
    input  logic         ab_oe_n,
    input  logic         ba_le,
    input  logic         ba_clk,
    input  logic         ba_clken_n,
    input  logic         ba_oe_n,
    output logic [W-1:0] b_tx_data,
    output logic         b_tx_en,
    output logic [W-1:0] a_tx_data,
    output logic         a_tx_en
);
    logic [W-1:0] a_eff;
    logic [W-1:0] b_eff;
    lane_ctrl_t   ab_ctrl;
    lane_ctrl_t   ba_ctrl;

    always_comb begin
        ab_ctrl = '{le: ab_le, dclk: ab_clk, clken_n: ab_clken_n, oe_n: ab_oe_n};
        ba_ctrl = '{le: ba_le, dclk: ba_clk, clken_n: ba_clken_n, oe_n: ba_oe_n};
    end

    ubr_keeper #(.W(W)) u_keep_a (
        .clk (clk), .rst (rst), .pad_val (a_rx_data), .pad_drv (a_rx_drv), .eff (a_eff)
    );

    ubr_keeper #(.W(W)) u_keep_b (
        .clk (clk), .rst (rst), .pad_val (b_rx_data), .pad_drv (b_rx_drv), .eff (b_eff)
    );

    ubr_lane #(.W(W)) u_lane_ab (
        .clk (clk), .rst (rst), .ctrl (ab_ctrl), .din (a_eff),
        .tx_data (b_tx_data), .tx_en (b_tx_en)
    );

    ubr_lane #(.W(W)) u_lane_ba (
        .clk (clk), .rst (rst), .ctrl (ba_ctrl), .din (b_eff),
        .tx_data (a_tx_data), .tx_en (a_tx_en)
    );
endmodule

// File: rtl/ubr_xcvr_chk.sv
module ubr_xcvr_chk #(
    parameter int unsigned W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_rx_data,
    input logic [W-1:0] a_rx_drv,
    input logic [W-1:0] b_rx_data,
    input logic [W-1:0] b_rx_drv,
    input logic         ab_le,
    input logic         ab_clk,
    input logic         ab_clken_n,
    input logic         ab_oe_n,
    input logic         ba_le,
    input logic         ba_clk,
    input logic         ba_clken_n,
    input logic         ba_oe_n,
    input logic [W-1:0] b_tx_data,
    input logic         b_tx_en,
    input logic [W-1:0] a_tx_data,
    input logic         a_tx_en
);
    // R1
    ab_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (ab_le && !ab_oe_n && (&a_rx_drv)) |-> (b_tx_data == a_rx_data));

    // R7
    ba_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (ba_le && !ba_oe_n && (&b_rx_drv)) |-> (a_tx_data == b_rx_data));

    // R5
    ab_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        ab_oe_n |-> (!b_tx_en && b_tx_data == '0));

    // R7
    ba_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        ba_oe_n |-> (!a_tx_en && a_tx_data == '0));

    // R5
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        !(!ab_oe_n && !ba_oe_n));

    // R2
    ab_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !ab_le && !$past(ab_le) && !ab_oe_n && !$past(ab_oe_n)
         && !($past(ab_clk) && !$past(ab_clk, 2))) |-> $stable(b_tx_data));

    // R4
    ab_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !ab_le && !$past(ab_le) && !ab_oe_n && !$past(ab_oe_n)
         && $past(ab_clken_n)) |-> $stable(b_tx_data));

    // R3
    ab_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !ab_le && !$past(ab_le) && !ab_oe_n
         && !$past(ab_clken_n) && $past(ab_clk) && !$past(ab_clk, 2)
         && (&$past(a_rx_drv))) |-> (b_tx_data == $past(a_rx_data)));

    // R8
    keeper_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(a_rx_drv[0]) && !a_rx_drv[0] && ab_le && !ab_oe_n)
        |-> (b_tx_data[0] == $past(a_rx_data[0])));
endmodule

bind ubr_xcvr ubr_xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/ubr_xcvr_bench.sv
module ubr_xcvr_bench;
    localparam int W = 18;
    localparam int ALL = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_rx_data = '0, a_rx_drv = '1, b_rx_data = '0, b_rx_drv = '1;
    logic ab_le = 0, ab_clk = 0, ab_clken_n = 1, ab_oe_n = 1;
    logic ba_le = 0, ba_clk = 0, ba_clken_n = 1, ba_oe_n = 1;
    logic [W-1:0] b_tx_data, a_tx_data;
    logic         b_tx_en, a_tx_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string        req;
        bit           a_side;
        logic         en;
        logic [W-1:0] data;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;

    always #4 clk = ~clk;

    ubr_xcvr #(.W(W)) u_ubr_xcvr (.*);

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_b(string req, logic en, logic [W-1:0] d);
        exp_t e;
        #1;
        e.req = req; e.a_side = 0; e.en = en; e.data = d;
        exp_q.push_back(e);
        -> sample_ev;
        #1;
    endtask

    task automatic expect_a(string req, logic en, logic [W-1:0] d);
        exp_t e;
        #1;
        e.req = req; e.a_side = 1; e.en = en; e.data = d;
        exp_q.push_back(e);
        -> sample_ev;
        #1;
    endtask

    // Monitor: pop and compare
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                logic         got_en;
                logic [W-1:0] got_d;
                e = exp_q.pop_front();
                got_en = e.a_side ? a_tx_en : b_tx_en;
                got_d  = e.a_side ? a_tx_data : b_tx_data;
                checks++;
                if (got_en !== e.en || got_d !== e.data) begin
                    errors++;
                    $display("FAIL %s: got en=%0b data=%05h expected en=%0b data=%05h",
                             e.req, got_en, got_d, e.en, e.data);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        rst = 0;
        // R5 disabled port drives nothing
        expect_b("R5", 1'b0, '0);
        // R9 reset leaves zero stored
        ab_oe_n = 0;
        expect_b("R9", 1'b1, '0);

        // R1 pass-through, two patterns
        ab_le = 1; a_rx_data = 18'h2A5C3;
        expect_b("R1", 1'b1, 18'h2A5C3);
        a_rx_data = 18'h1F00F;
        expect_b("R1", 1'b1, 18'h1F00F);
        step();

        // R6 closing pass-through keeps last sampled input
        ab_le = 0; a_rx_data = 18'h00FF0;
        expect_b("R6", 1'b1, 18'h1F00F);
        step();
        expect_b("R2", 1'b1, 18'h1F00F);

        // R3 capture on qualified rising data clock
        ab_clken_n = 0; a_rx_data = 18'h12345; ab_clk = 1;
        expect_b("R3", 1'b1, 18'h1F00F);
        step();
        expect_b("R3", 1'b1, 18'h12345);
        a_rx_data = 18'h3FFFF;
        step();
        expect_b("R2", 1'b1, 18'h12345);
        ab_clk = 0;
        step();
        expect_b("R2", 1'b1, 18'h12345);

        // R4 gated edge ignored
        ab_clken_n = 1; a_rx_data = 18'h0AAAA; ab_clk = 1;
        step(); step();
        expect_b("R4", 1'b1, 18'h12345);
        ab_clk = 0;
        step();

        // R5 disable while in pass-through
        ab_oe_n = 1; ab_le = 1;
        expect_b("R5", 1'b0, '0);
        ab_le = 0;

        // R7 reverse path
        ba_oe_n = 0; ba_le = 1; b_rx_data = 18'h15555;
        expect_a("R7", 1'b1, 18'h15555);
        step();
        ba_le = 0; ba_clken_n = 0; b_rx_data = 18'h2BCDE; ba_clk = 1;
        step();
        expect_a("R7", 1'b1, 18'h2BCDE);
        b_rx_data = 18'h00001; ab_le = 1; ab_clken_n = 0; ab_clk = 0;
        step();
        ab_clk = 1;
        step();
        expect_a("R7", 1'b1, 18'h2BCDE);
        ba_clken_n = 1; ba_clk = 0; ab_le = 0; ab_clk = 0; ab_clken_n = 1;
        step();
        ba_oe_n = 1;
        expect_a("R7", 1'b0, '0);
        ab_oe_n = 0;
        expect_b("R7", 1'b1, 18'h0AAAA);

        // R8 keeper
        ab_le = 1; a_rx_data = 18'h3C3C3; a_rx_drv = '1;
        step();
        a_rx_drv = '0; a_rx_data = '0;
        expect_b("R8", 1'b1, 18'h3C3C3);
        a_rx_drv = 18'h000FF; a_rx_data = 18'h00055;
        expect_b("R8", 1'b1, 18'h3C355);
        step();
        a_rx_drv = '0; a_rx_data = 18'(ALL);
        expect_b("R8", 1'b1, 18'h3C355);

        // R9 reset mid-run with data clock held high
        ab_le = 0; ab_clk = 1; rst = 1;
        step();
        rst = 0;
        expect_b("R9", 1'b1, '0);
        ab_le = 1;
        expect_b("R9", 1'b1, '0);
        ab_le = 0; ab_clken_n = 0; a_rx_drv = '1; a_rx_data = 18'h11111;
        step();
        expect_b("R9", 1'b1, '0);

        step();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule